// File: doc/BRIEF.md
# Critical-Conduction PFC Gate Sequencer

This block is the digital timing core of a boost power-factor preconverter running in critical-conduction mode. It turns five asynchronous comparator flags into one gate-drive output. The flags are inductor zero-current, switch-current trip, feedback-present enable, error-amplifier level and supply good. A switching cycle starts when the inductor current returns to zero, which is seen as a falling edge of the zero-current flag. The cycle ends when the sensed switch current reaches the reference. A current trip that arrives during a blanking window after turn-on is not acted on.

A restart timer fires a new on-time when no zero-current event has arrived for a long idle gap. The gate is forced low and the sequencer is parked whenever one of three conditions holds: supply good is low, the feedback-present flag is low, or the error-amplifier flag has stayed low for a filtered delay. The state and a count of timer-forced restarts are reported as status outputs. Every time constant is derived from a clock-frequency parameter given in MHz.

Top module: `pfc_gate_seq`

## Requirements
- R1: A falling edge of `zcd_i` seen while the sequencer waits raises `gate_o` on the third rising clock edge after the input change. A rising edge, or a steady level, starts nothing.
- R2: Once blanking is over, a high `cs_trip_i` drops `gate_o` on the third rising clock edge after it rises. The sequencer then returns to waiting.
- R3: For `LEB_CYC` cycles after turn-on the current trip is ignored. An on-time therefore lasts max(d+3, LEB_CYC+1) cycles, where d is the number of cycles from the first high gate sample to the trip rising.
- R4: An on-time gives exactly one rising and one falling gate edge. A zero-current fall that occurs while the gate is high is discarded and does not start a second pulse after turn-off.
- R5: If the gate stays low in the waiting state for CLK_MHZ*RESTART_US cycles, the next cycle is started without a zero-current event. Each such restart adds one to `restart_cnt_o`, which saturates at its maximum.
- R6: A low `fb_en_i` forces `gate_o` low on the third rising edge after the change and parks the sequencer in the off state.
- R7: A low `ea_ok_i` parks the sequencer only after it has been low for CLK_MHZ*INHIBIT_US consecutive synchronized cycles. A shorter low pulse has no effect on the gate.
- R8: A low `vcc_ok_i` forces `gate_o` low on the third rising edge after the change. The sequencer leaves the off state only while supply good, enable and no inhibit all hold.
- R9: While `rst_ni` is low, `gate_o` is 0, `state_o` is off and `restart_cnt_o` is 0.
- R10: `state_o` encodes off as 0, waiting as 1 and on as 2. From off with all conditions good, the sequencer enters waiting within four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| zcd_i | input | 1 | Zero-current detector flag, asynchronous |
| cs_trip_i | input | 1 | Switch-current trip flag, asynchronous |
| fb_en_i | input | 1 | Feedback-present enable, asynchronous |
| ea_ok_i | input | 1 | Error amplifier above inhibit level, asynchronous |
| vcc_ok_i | input | 1 | Supply above turn-on threshold, asynchronous |
| gate_o | output | 1 | Gate-drive command |
| state_o | output | 2 | Sequencer state: 0 off, 1 wait, 2 on |
| restart_cnt_o | output | CNT_W | Saturating count of timer-forced restarts |

## Verification
On-times are driven with trip delays spread at random on both sides of the blanking boundary. An early trip that is held off must give a different pulse width from a late one, which separates the blanking logic from the trip path. Zero-current falls are tried both while waiting and during an on-time, which separates the turn-on trigger from the double-pulse guard. A long idle gap with the detector held high isolates the restart timer. Error-amplifier pulses one cycle shorter than the inhibit delay, and then longer ones, distinguish the filter from a direct gate kill. The enable and supply drops are timed to the edge to confirm their fixed three-cycle path.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/pfc_inhibit_filter.sv
module pfc_inhibit_filter #(
  parameter int DLY = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ea_low_i,
  output logic inhibit_o
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] CMAX = CW'(DLY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!ea_low_i)     cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign inhibit_o = (cnt_q == CMAX);

  p_inhibit_needs_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inhibit_o) |-> $past(ea_low_i));
  p_inhibit_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ea_low_i |=> !inhibit_o);
endmodule

// File: rtl/pfc_seq_core.sv
module pfc_seq_core
  import pfc_pkg::*;
#(
  parameter int LEB_CYC     = 20,
  parameter int RESTART_CYC = 15000,
  parameter int CNT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_ok_i,
  input  logic             zcd_s_i,
  input  logic             cs_s_i,
  output seq_state_e       state_o,
  output logic [CNT_W-1:0] restart_cnt_o
);
  localparam int LW = $clog2(LEB_CYC + 1);
  localparam int IW = $clog2(RESTART_CYC);
  localparam logic [LW-1:0] LEB_MAX  = LW'(LEB_CYC);
  localparam logic [IW-1:0] IDLE_MAX = IW'(RESTART_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [LW-1:0]    leb_q, leb_d;
  logic [IW-1:0]    idle_q, idle_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             zcd_d_q;
  logic             zcd_fall, leb_done, timeout;

  assign zcd_fall = zcd_d_q & ~zcd_s_i;
  assign leb_done = (leb_q == LEB_MAX);
  assign timeout  = (idle_q == IDLE_MAX);

  always_comb begin
    state_d = state_q;
    leb_d   = leb_q;
    idle_d  = idle_q;
    cnt_d   = cnt_q;
    if (!run_ok_i) begin
      state_d = ST_OFF;
      leb_d   = '0;
      idle_d  = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = ST_WAIT;
          idle_d  = '0;
        end
        ST_WAIT: begin
          if (zcd_fall || timeout) begin
            state_d = ST_ON;
            leb_d   = '0;
            idle_d  = '0;
            // timer-forced start only when no zero-current event
            if (!zcd_fall && cnt_q != '1) cnt_d = cnt_q + 1'b1;
          end else begin
            idle_d = idle_q + 1'b1;
          end
        end
        ST_ON: begin
          if (!leb_done) leb_d = leb_q + 1'b1;
          else if (cs_s_i) begin
            state_d = ST_WAIT;
            idle_d  = '0;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      leb_q   <= '0;
      idle_q  <= '0;
      cnt_q   <= '0;
      zcd_d_q <= 1'b0;
    end else begin
      state_q <= state_d;
      leb_q   <= leb_d;
      idle_q  <= idle_d;
      cnt_q   <= cnt_d;
      zcd_d_q <= zcd_s_i;
    end
  end

  assign state_o       = state_q;
  assign restart_cnt_o = cnt_q;

  p_trip_ends_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && leb_done && cs_s_i) |=> state_q != ST_ON);
  p_blank_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && !leb_done && run_ok_i) |=> state_q == ST_ON);
  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !zcd_fall && !timeout) |=> state_q != ST_ON);
  p_idle_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> idle_q <= IDLE_MAX);
  p_cnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pfc_gate_seq.sv
module pfc_gate_seq
  import pfc_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int LEB_CYC    = 20,
  parameter int RESTART_US = 150,
  parameter int INHIBIT_US = 2,
  parameter int CNT_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zcd_i,
  input  logic             cs_trip_i,
  input  logic             fb_en_i,
  input  logic             ea_ok_i,
  input  logic             vcc_ok_i,
  output logic             gate_o,
  output logic [1:0]       state_o,
  output logic [CNT_W-1:0] restart_cnt_o
);
  localparam int RESTART_CYC = CLK_MHZ * RESTART_US;
  localparam int INHIBIT_CYC = CLK_MHZ * INHIBIT_US;

  logic [4:0] raw, syn;
  logic       zcd_s, cs_s, fb_s, ea_s, vcc_s;
  logic       inhibit, run_ok;
  seq_state_e state;

  assign raw = {vcc_ok_i, ea_ok_i, fb_en_i, cs_trip_i, zcd_i};

  pfc_sync #(.W(5)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {vcc_s, ea_s, fb_s, cs_s, zcd_s} = syn;

  pfc_inhibit_filter #(.DLY(INHIBIT_CYC)) u_inh (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ea_low_i (~ea_s),
    .inhibit_o(inhibit)
  );

  assign run_ok = vcc_s & fb_s & ~inhibit;

  pfc_seq_core #(
    .LEB_CYC    (LEB_CYC),
    .RESTART_CYC(RESTART_CYC),
    .CNT_W      (CNT_W)
  ) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_ok_i     (run_ok),
    .zcd_s_i      (zcd_s),
    .cs_s_i       (cs_s),
    .state_o      (state),
    .restart_cnt_o(restart_cnt_o)
  );

  assign gate_o  = (state == ST_ON);
  assign state_o = state;

  p_enable_gates_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_s |=> !gate_o);
  p_uvlo_gates_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_s |=> !gate_o);
  p_inhibit_gates_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit |=> !gate_o);
  p_state_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);
endmodule

// File: tb/pfc_gate_seq_tb.sv
`timescale 1ns/1ps
module pfc_gate_seq_tb_top;
  localparam int CLK_MHZ = 4;
  localparam int LEB     = 6;
  localparam int RUS     = 150;
  localparam int IUS     = 5;
  localparam int CW      = 8;
  localparam int RCYC    = CLK_MHZ * RUS;
  localparam int ICYC    = CLK_MHZ * IUS;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic zcd_i = 1'b1, cs_trip_i = 1'b0, fb_en_i = 1'b1, ea_ok_i = 1'b1, vcc_ok_i = 1'b1;
  logic gate_o;
  logic [1:0] state_o;
  logic [CW-1:0] restart_cnt_o;

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfc_gate_seq #(
    .CLK_MHZ(CLK_MHZ), .LEB_CYC(LEB), .RESTART_US(RUS), .INHIBIT_US(IUS), .CNT_W(CW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .zcd_i(zcd_i), .cs_trip_i(cs_trip_i),
    .fb_en_i(fb_en_i), .ea_ok_i(ea_ok_i), .vcc_ok_i(vcc_ok_i),
    .gate_o(gate_o), .state_o(state_o), .restart_cnt_o(restart_cnt_o)
  );

  function automatic int exp_on(input int d);
    return (d + 3 > LEB + 1) ? d + 3 : LEB + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // zero-current fall while waiting; ends on first high gate sample
  task automatic zcd_turn_on();
    @(negedge clk); zcd_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(gate_o == 1'b0, "R1 latency early", gate_o, 0);
    @(negedge clk);
    chk(gate_o == 1'b1, "R1 turn-on", gate_o, 1);
    zcd_i = 1'b1;
  endtask

  // starts at a high gate sample, trip at sample d, returns at first low sample
  task automatic run_on(input int d, input int expd, input string req);
    int n = 0;
    for (int i = 0; i < 2000; i++) begin
      if (i == d) cs_trip_i = 1'b1;
      if (gate_o) n++;
      else break;
      @(negedge clk);
    end
    chk(n == expd, req, n, expd);
    cs_trip_i = 1'b0;
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(1234);
    // R9 reset state
    repeat (4) @(negedge clk);
    chk(gate_o == 1'b0, "R9 gate in reset", gate_o, 0);
    chk(state_o == 2'd0, "R9 state in reset", state_o, 0);
    chk(restart_cnt_o == 0, "R9 count in reset", restart_cnt_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(state_o == 2'd1, "R10 wait after start", state_o, 1);
    repeat (4) @(negedge clk);
    chk(gate_o == 1'b0, "R1 steady zcd no start", gate_o, 0);

    // R1/R2/R3 directed: trip early (blanked) and trip late
    zcd_turn_on();
    run_on(0, exp_on(0), "R3 blanked trip");
    repeat (5) @(negedge clk);
    zcd_turn_on();
    run_on(LEB + 4, exp_on(LEB + 4), "R2 late trip");
    repeat (5) @(negedge clk);

    // R4 zcd fall during on-time ignored
    zcd_turn_on();
    @(negedge clk); zcd_i = 1'b0;
    repeat (3) @(negedge clk); zcd_i = 1'b1;
    repeat (LEB + 4) @(negedge clk);
    chk(gate_o == 1'b1, "R4 still on after zcd fall", gate_o, 1);
    run_on(0, 3, "R2 trip after blanking");
    begin
      int hi = 0;
      for (int i = 0; i < 12; i++) begin
        if (gate_o) hi++;
        @(negedge clk);
      end
      chk(hi == 0, "R4 no second pulse", hi, 0);
    end

    // R5 restart timer: gate low exactly RCYC cycles with zcd held high
    zcd_turn_on();
    run_on(LEB, exp_on(LEB), "R3 on-time before idle");
    begin
      int lo = 0;
      while (!gate_o && lo < 5 * RCYC) begin
        lo++;
        @(negedge clk);
      end
      chk(lo == RCYC, "R5 restart gap", lo, RCYC);
    end
    exp_cnt++;
    chk(restart_cnt_o == exp_cnt, "R5 restart count", restart_cnt_o, exp_cnt);
    run_on(LEB + 2, exp_on(LEB + 2), "R5 restarted on-time");
    repeat (5) @(negedge clk);

    // R6 enable drop
    zcd_turn_on();
    @(negedge clk); fb_en_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(gate_o == 1'b1, "R6 enable path latency", gate_o, 1);
    @(negedge clk);
    chk(gate_o == 1'b0, "R6 enable forces off", gate_o, 0);
    chk(state_o == 2'd0, "R6 state off", state_o, 0);
    fb_en_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(state_o == 2'd1, "R10 resume to wait", state_o, 1);

    // R8 supply drop
    zcd_turn_on();
    @(negedge clk); vcc_ok_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(gate_o == 1'b1, "R8 uvlo path latency", gate_o, 1);
    @(negedge clk);
    chk(gate_o == 1'b0, "R8 uvlo forces off", gate_o, 0);
    repeat (6) @(negedge clk);
    chk(state_o == 2'd0, "R8 held off", state_o, 0);
    zcd_i = 1'b0; repeat (4) @(negedge clk); zcd_i = 1'b1;
    chk(gate_o == 1'b0, "R8 zcd ignored in lockout", gate_o, 0);
    vcc_ok_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(state_o == 2'd1, "R8 resume", state_o, 1);

    // R7 short inhibit pulse ignored, long one parks
    zcd_turn_on();
    @(negedge clk); ea_ok_i = 1'b0;
    repeat (ICYC - 1) @(negedge clk);
    ea_ok_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(gate_o == 1'b1, "R7 short pulse ignored", gate_o, 1);
    @(negedge clk); ea_ok_i = 1'b0;
    repeat (ICYC + 2) @(negedge clk);
    chk(state_o == 2'd2, "R7 before delay", state_o, 2);
    @(negedge clk);
    chk(state_o == 2'd0, "R7 inhibit parks", state_o, 0);
    chk(gate_o == 1'b0, "R7 gate off", gate_o, 0);
    ea_ok_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(state_o == 2'd1, "R7 resume", state_o, 1);

    // random on-times around the blanking edge
    for (int k = 0; k < 30; k++) begin
      int d, gap;
      d   = $urandom % (2 * LEB + 4);
      gap = 4 + $urandom % 16;
      repeat (gap) @(negedge clk);
      zcd_turn_on();
      run_on(d, exp_on(d), "R3 random on-time");
    end
    chk(restart_cnt_o == exp_cnt, "R5 count unchanged", restart_cnt_o, exp_cnt);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule